// File: doc/BRIEF.md
# Two-Bank Byte/Word Access Sequencer

This block sits between a processor-side request port and a 16-bit memory built from two byte-wide banks. The even bank holds every byte whose address has bit 0 clear. The odd bank holds every byte whose address has bit 0 set. Both banks share one 19-bit location address taken from byte-address bits 19..1. A request carries a 20-bit byte address, a byte/word flag, a read/write flag and 16 bits of write data. The sequencer turns each request into one or two bus cycles. It drives the bank address, the address bit 0 line (which also acts as the active-low even-bank select) and an active-low high-byte enable. It steers bytes onto the correct half of the 16-bit data bus.

Words are little-endian: the low byte lives at the word's own address and the high byte at the next address. A byte access, or a word access at an even address, needs one bus cycle. A word at an odd address is split into two bus cycles. The first cycle moves the low byte through the odd bank on the upper lanes. The second cycle uses the next address to move the high byte through the even bank on the lower lanes. On a read, the first byte is held until the second byte arrives, and then the word is returned. Two small synchronous byte memories stand in for the banks so that the block can be exercised end to end.

The controller has five states:
- `ST_IDLE` waits for a request.
- `ST_FULL` is the single bus cycle of a byte access or of an aligned word access.
- `ST_SPLIT_LO` is the first cycle of a split (odd-address) word.
- `ST_SPLIT_HI` is the second cycle of a split word.
- `ST_DONE` returns the result.

The transitions are:
- `ST_IDLE` to `ST_FULL` on accepting a byte request or an even-address word request.
- `ST_IDLE` to `ST_SPLIT_LO` on accepting an odd-address word request.
- `ST_SPLIT_LO` to `ST_SPLIT_HI`, always.
- `ST_FULL` to `ST_DONE` and `ST_SPLIT_HI` to `ST_DONE`, always.
- `ST_DONE` to `ST_IDLE`, always.

Top module: `dual_bank_seq`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, `bus_cyc` is 0 and `rsp_done` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in `ST_IDLE`. A `req_valid` held high while the block is busy starts no bus cycle and changes no memory byte.
- R3: A byte access to an even address takes one bus cycle with `bus_a0`=0 and `bus_hben_n`=1. Write data `req_wdata[7:0]` goes on `bus_wdata[7:0]`. The read result is the even-bank byte in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0.
- R4: A byte access to an odd address takes one bus cycle with `bus_a0`=1 and `bus_hben_n`=0. Write data `req_wdata[7:0]` goes on `bus_wdata[15:8]`. The read result is the odd-bank byte in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0.
- R5: A word access to an even address takes one bus cycle with `bus_a0`=0 and `bus_hben_n`=0. All 16 bits of `req_wdata` go on `bus_wdata` unchanged.
- R6: A word access to an odd address A takes two consecutive bus cycles.
  - The first cycle uses `bus_addr`=A[19:1], `bus_a0`=1 and `bus_hben_n`=0, with `req_wdata[7:0]` on `bus_wdata[15:8]`.
  - The second cycle uses byte address A+1 with `bus_a0`=0 and `bus_hben_n`=1, with `req_wdata[15:8]` on `bus_wdata[7:0]`.
- R7: Word data is little-endian. A word read at address A returns {byte at A+1, byte at A}, for even and odd A alike.
- R8: A byte write leaves the other byte of the same bank address unchanged.
- R9: Each request raises `rsp_done` for exactly one cycle. This happens 2 cycles after the accepting edge for a one-cycle access and 3 cycles after it for a split word. `req_ready` returns to 1 in the cycle after `rsp_done`.
- R10: The address of the second cycle wraps modulo 2^20. A word access at 0xFFFFF uses bank address 0x7FFFF in the odd bank, then bank address 0x00000 in the even bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 20 | Byte address of the access |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte accesses use bits 7..0) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Assembled read data, valid while `rsp_done` is 1 |
| bus_cyc | output | 1 | A bank bus cycle is in progress |
| bus_wr | output | 1 | The current bus cycle writes |
| bus_addr | output | 19 | Location address within both banks |
| bus_a0 | output | 1 | Address bit 0, active-low even-bank select |
| bus_hben_n | output | 1 | Active-low odd-bank (high byte) enable |
| bus_wdata | output | 16 | Byte-steered write data lanes |

## Verification
The bench builds the block with the full 20-bit address and with 8 location bits kept in each bank model. That gives a 512-byte memory in which every byte can be filled and mirrored by a reference array. Because the model reuses its locations modulo 256, the wrap of a split word from 0xFFFFF to 0x00000 lands on two real locations. Its data then returns through the same reference array as any other access. The small model also keeps filling and checking both banks cheap. Meanwhile the bus address and lane checks still see all 19 address bits that the sequencer drives.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FULL,
        ST_SPLIT_LO,
        ST_SPLIT_HI,
        ST_DONE
    } seq_state_t;

    // which request byte lands on which bus lane in the current cycle
    typedef enum logic [2:0] {
        LM_NONE,
        LM_B0_LOW,
        LM_B0_HIGH,
        LM_B1_LOW,
        LM_WORD
    } lane_mode_t;

    // access kind, fixed when a request is accepted
    typedef enum logic [1:0] {
        AK_BYTE_EVEN,
        AK_BYTE_ODD,
        AK_WORD_EVEN,
        AK_WORD_ODD
    } acc_kind_t;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;

endpackage

// File: rtl/dbs_bank_mem.sv
module dbs_bank_mem #(
    parameter int DEPTH_W = 8
) (
    input  logic               clk,
    input  logic               en,
    input  logic               we,
    input  logic [DEPTH_W-1:0] addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata
);
    localparam int DEPTH = 1 << DEPTH_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    output logic              req_ready,
    output logic              accept,
    output logic              bus_cyc,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_byte_addr,
    output logic              bus_hben_n,
    output lane_mode_t        lane_mode,
    output acc_kind_t         kind,
    output logic              cap_first,
    output logic              done
);
    seq_state_t        st, st_nxt;
    logic [ADDR_W-1:0] r_addr;
    logic              r_write;
    acc_kind_t         r_kind;
    acc_kind_t         in_kind;

    assign accept = (st == ST_IDLE) && req_valid;
    assign kind   = r_kind;

    always_comb begin
        unique case ({req_word, req_addr[0]})
            2'b00:   in_kind = AK_BYTE_EVEN;
            2'b01:   in_kind = AK_BYTE_ODD;
            2'b10:   in_kind = AK_WORD_EVEN;
            default: in_kind = AK_WORD_ODD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_write <= 1'b0;
            r_kind  <= AK_BYTE_EVEN;
        end else if (accept) begin
            r_addr  <= req_addr;
            r_write <= req_write;
            r_kind  <= in_kind;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_nxt = (in_kind == AK_WORD_ODD) ? ST_SPLIT_LO : ST_FULL;
                end
            end
            ST_FULL:     st_nxt = ST_DONE;
            ST_SPLIT_LO: st_nxt = ST_SPLIT_HI;
            ST_SPLIT_HI: st_nxt = ST_DONE;
            ST_DONE:     st_nxt = ST_IDLE;
            default:     st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        bus_cyc       = 1'b0;
        bus_wr        = 1'b0;
        bus_byte_addr = r_addr;
        bus_hben_n    = 1'b1;
        lane_mode     = LM_NONE;
        cap_first     = 1'b0;
        done          = 1'b0;
        unique case (st)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_FULL: begin
                bus_cyc = 1'b1;
                bus_wr  = r_write;
                unique case (r_kind)
                    AK_BYTE_EVEN: begin
                        bus_hben_n = 1'b1;
                        lane_mode  = LM_B0_LOW;
                    end
                    AK_BYTE_ODD: begin
                        bus_hben_n = 1'b0;
                        lane_mode  = LM_B0_HIGH;
                    end
                    AK_WORD_EVEN: begin
                        bus_hben_n = 1'b0;
                        lane_mode  = LM_WORD;
                    end
                    default: begin
                        bus_hben_n = 1'b1;
                        lane_mode  = LM_NONE;
                    end
                endcase
            end
            ST_SPLIT_LO: begin
                bus_cyc    = 1'b1;
                bus_wr     = r_write;
                bus_hben_n = 1'b0;
                lane_mode  = LM_B0_HIGH;
            end
            ST_SPLIT_HI: begin
                bus_cyc       = 1'b1;
                bus_wr        = r_write;
                bus_byte_addr = r_addr + 1'b1;
                bus_hben_n    = 1'b1;
                lane_mode     = LM_B1_LOW;
                cap_first     = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbs_lanes.sv
module dbs_lanes
    import dbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic [15:0] req_wdata,
    input  lane_mode_t  lane_mode,
    input  acc_kind_t   kind,
    input  logic        cap_first,
    input  logic        done,
    input  logic [15:0] bank_rd,
    output logic [15:0] bus_wdata,
    output logic [15:0] rsp_rdata
);
    logic [15:0] r_wdata;
    logic [7:0]  first_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_wdata    <= '0;
            first_byte <= '0;
        end else begin
            if (accept) begin
                r_wdata <= req_wdata;
            end
            // odd-bank byte read during the first split cycle
            if (cap_first) begin
                first_byte <= bank_rd[15:8];
            end
        end
    end

    always_comb begin
        unique case (lane_mode)
            LM_B0_LOW:  bus_wdata = {8'h00, r_wdata[7:0]};
            LM_B0_HIGH: bus_wdata = {r_wdata[7:0], 8'h00};
            LM_B1_LOW:  bus_wdata = {8'h00, r_wdata[15:8]};
            LM_WORD:    bus_wdata = r_wdata;
            default:    bus_wdata = 16'h0000;
        endcase
    end

    always_comb begin
        rsp_rdata = 16'h0000;
        if (done) begin
            unique case (kind)
                AK_BYTE_EVEN: rsp_rdata = {8'h00, bank_rd[7:0]};
                AK_BYTE_ODD:  rsp_rdata = {8'h00, bank_rd[15:8]};
                AK_WORD_EVEN: rsp_rdata = bank_rd;
                default:      rsp_rdata = {bank_rd[7:0], first_byte};
            endcase
        end
    end

endmodule

// File: rtl/dual_bank_seq.sv
module dual_bank_seq
    import dbs_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int MODEL_DEPTH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic              bus_cyc,
    output logic              bus_wr,
    output logic [ADDR_W-2:0] bus_addr,
    output logic              bus_a0,
    output logic              bus_hben_n,
    output logic [15:0]       bus_wdata
);
    localparam int BANK_AW = ADDR_W - 1;

    logic              accept;
    logic              cap_first;
    logic [ADDR_W-1:0] byte_addr;
    lane_mode_t        lane_mode;
    acc_kind_t         kind;
    logic [15:0]       bank_rd;
    logic [LANES-1:0]  bank_en;

    dbs_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_word      (req_word),
        .req_write     (req_write),
        .req_ready     (req_ready),
        .accept        (accept),
        .bus_cyc       (bus_cyc),
        .bus_wr        (bus_wr),
        .bus_byte_addr (byte_addr),
        .bus_hben_n    (bus_hben_n),
        .lane_mode     (lane_mode),
        .kind          (kind),
        .cap_first     (cap_first),
        .done          (rsp_done)
    );

    assign bus_addr = byte_addr[ADDR_W-1:1];
    assign bus_a0   = byte_addr[0];

    dbs_lanes u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .lane_mode (lane_mode),
        .kind      (kind),
        .cap_first (cap_first),
        .done      (rsp_done),
        .bank_rd   (bank_rd),
        .bus_wdata (bus_wdata),
        .rsp_rdata (rsp_rdata)
    );

    // bank 0 answers to a low address bit 0, bank 1 to a low high-byte enable
    generate
        for (genvar gi = 0; gi < LANES; gi++) begin : g_bank
            if (gi == 0) begin : g_even
                assign bank_en[gi] = bus_cyc && !bus_a0;
            end else begin : g_odd
                assign bank_en[gi] = bus_cyc && !bus_hben_n;
            end
            dbs_bank_mem #(.DEPTH_W(MODEL_DEPTH_W)) u_mem (
                .clk   (clk),
                .en    (bank_en[gi]),
                .we    (bus_wr),
                .addr  (bus_addr[MODEL_DEPTH_W-1:0]),
                .wdata (bus_wdata[gi*BYTE_W +: BYTE_W]),
                .rdata (bank_rd[gi*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    initial begin
        if (MODEL_DEPTH_W > BANK_AW) $error("bank model deeper than bank address");
    end

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              bus_cyc,
    input logic [ADDR_W-2:0] bus_addr,
    input logic              bus_a0,
    input logic              bus_hben_n
);
    // R3/R4/R5: a bus cycle always enables at least one bank
    p_one_bank_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !(bus_a0 && bus_hben_n));

    // R2: no bus activity while idle, and a cycle starts only after a taken request
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_cyc);

    p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> $past(req_valid && req_ready));

    // R6: a back-to-back second cycle follows an odd-bank cycle and uses the even bank
    p_split_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> (!bus_a0 && bus_hben_n && $past(bus_a0) && !$past(bus_hben_n)));

    // R10: the second cycle's byte address is the first plus one, modulo 2^20
    p_next_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> ({bus_addr, bus_a0} == $past({bus_addr, bus_a0}) + 1'b1));

    // R9: done follows the last bus cycle, lasts one cycle, then the port is free
    p_done_after_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cyc) |-> rsp_done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

endmodule

bind dual_bank_seq dbs_checker #(.ADDR_W(ADDR_W)) u_dbs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .bus_cyc    (bus_cyc),
    .bus_addr   (bus_addr),
    .bus_a0     (bus_a0),
    .bus_hben_n (bus_hben_n)
);

// File: tb/dual_bank_seq_bench.sv
`timescale 1ns/1ps
module dual_bank_seq_bench;
    localparam int AW = 20;
    localparam int DW = 8;
    localparam int MEM_BYTES = 1 << (DW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_word = 1'b0;
    logic          req_write = 1'b0;
    logic [15:0]   req_wdata = '0;
    logic          rsp_done;
    logic [15:0]   rsp_rdata;
    logic          bus_cyc, bus_wr, bus_a0, bus_hben_n;
    logic [AW-2:0] bus_addr;
    logic [15:0]   bus_wdata;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [7:0] ref_mem [MEM_BYTES];

    always #4 clk = ~clk;

    dual_bank_seq #(.ADDR_W(AW), .MODEL_DEPTH_W(DW)) u_dual_bank_seq (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_word, .req_write,
        .req_wdata, .rsp_done, .rsp_rdata, .bus_cyc, .bus_wr, .bus_addr,
        .bus_a0, .bus_hben_n, .bus_wdata
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] midx(input logic [AW-1:0] a);
        return a[8:0];
    endfunction

    // one request, bus cycles and result checked against expectations from the requirements
    task automatic run_txn(input string req, input logic [AW-1:0] a, input logic w,
                           input logic wr, input logic [15:0] wd);
        logic [AW-1:0] a2;
        int            exp_n, n_cyc, lat;
        logic [AW-2:0] e_addr [2];
        logic          e_a0 [2], e_hb [2];
        logic [15:0]   e_mask [2], e_lane [2];
        logic [15:0]   exp_rd, got_rd;
        bit            seen;
        a2 = a + 1'b1;
        exp_n = (w && a[0]) ? 2 : 1;
        e_addr[0] = a[AW-1:1]; e_addr[1] = a2[AW-1:1];
        e_a0[0] = a[0];        e_a0[1] = 1'b0;
        e_hb[0] = !(w || a[0]); e_hb[1] = 1'b1;
        e_mask[1] = 16'h00FF;  e_lane[1] = {8'h00, wd[15:8]};
        if (w && !a[0]) begin
            e_mask[0] = 16'hFFFF; e_lane[0] = wd;
        end else if (a[0]) begin
            e_mask[0] = 16'hFF00; e_lane[0] = {wd[7:0], 8'h00};
        end else begin
            e_mask[0] = 16'h00FF; e_lane[0] = {8'h00, wd[7:0]};
        end
        exp_rd = w ? {ref_mem[midx(a2)], ref_mem[midx(a)]} : {8'h00, ref_mem[midx(a)]};

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_cyc = 0; lat = 1; seen = 1'b0; got_rd = '0;
        for (int k = 0; k < 8; k++) begin
            if (bus_cyc) begin
                if (n_cyc < 2) begin
                    check(req, "bus_addr", 32'(bus_addr), 32'(e_addr[n_cyc]));
                    check(req, "bus_a0", 32'(bus_a0), 32'(e_a0[n_cyc]));
                    check(req, "bus_hben_n", 32'(bus_hben_n), 32'(e_hb[n_cyc]));
                    check(req, "bus_wr", 32'(bus_wr), 32'(wr));
                    if (wr) check(req, "write lanes", 32'(bus_wdata & e_mask[n_cyc]),
                                  32'(e_lane[n_cyc] & e_mask[n_cyc]));
                end
                n_cyc++;
            end
            if (rsp_done) begin
                seen = 1'b1; got_rd = rsp_rdata;
                break;
            end
            @(negedge clk);
            lat++;
        end
        check(req, "bus cycle count", 32'(n_cyc), 32'(exp_n));
        check("R9", "done seen", 32'(seen), 32'd1);
        check("R9", "done latency", 32'(lat), 32'(exp_n + 1));
        if (!wr) check(req, "read data", 32'(got_rd), 32'(exp_rd));
        @(negedge clk);
        check("R9", "done single pulse", 32'(rsp_done), 32'd0);
        check("R9", "ready after done", 32'(req_ready), 32'd1);
        if (wr) begin
            ref_mem[midx(a)] = wd[7:0];
            if (w) ref_mem[midx(a2)] = wd[15:8];
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "ready in reset", 32'(req_ready), 32'd1);
        check("R1", "bus idle in reset", 32'(bus_cyc), 32'd0);
        check("R1", "done low in reset", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", 32'(req_ready), 32'd1);
        check("R1", "bus idle after reset", 32'(bus_cyc), 32'd0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < MEM_BYTES; i += 2) begin
            run_txn("R5", AW'(i), 1'b1, 1'b1, {8'(i) ^ 8'h5A, 8'(i) ^ 8'hC3});
        end
    endtask

    task automatic t_aligned_word;
        run_txn("R5", 20'h00020, 1'b1, 1'b0, 16'h0);
        run_txn("R5", 20'h00064, 1'b1, 1'b1, 16'hBEEF);
        run_txn("R7", 20'h00064, 1'b1, 1'b0, 16'h0);
    endtask

    task automatic t_byte_even;
        run_txn("R3", 20'h00010, 1'b0, 1'b1, 16'hFF11);
        run_txn("R3", 20'h00010, 1'b0, 1'b0, 16'h0);
        // R8: word read shows the odd neighbour untouched
        run_txn("R8", 20'h00010, 1'b1, 1'b0, 16'h0);
    endtask

    task automatic t_byte_odd;
        run_txn("R4", 20'h00033, 1'b0, 1'b1, 16'h0077);
        run_txn("R4", 20'h00033, 1'b0, 1'b0, 16'h0);
        // R8: even neighbour untouched
        run_txn("R8", 20'h00032, 1'b1, 1'b0, 16'h0);
    endtask

    task automatic t_word_odd;
        run_txn("R6", 20'h00045, 1'b1, 1'b1, 16'hA1B2);
        run_txn("R7", 20'h00045, 1'b1, 1'b0, 16'h0);
        run_txn("R7", 20'h00044, 1'b0, 1'b0, 16'h0);
        run_txn("R7", 20'h00046, 1'b0, 1'b0, 16'h0);
        run_txn("R6", 20'h0007B, 1'b1, 1'b0, 16'h0);
    endtask

    task automatic t_wrap;
        run_txn("R10", 20'hFFFFF, 1'b1, 1'b1, 16'h3C4D);
        run_txn("R10", 20'hFFFFF, 1'b1, 1'b0, 16'h0);
        run_txn("R10", 20'h00000, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] exp_rd;
        bit          seen;
        exp_rd = {ref_mem[midx(20'h00022)], ref_mem[midx(20'h00021)]};
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = 20'h00021; req_word = 1'b1; req_write = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // stray write held while busy
        req_addr = 20'h00040; req_word = 1'b0; req_write = 1'b1; req_wdata = 16'h00EE;
        check("R2", "ready low while busy", 32'(req_ready), 32'd0);
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (rsp_done) begin
                seen = 1'b1;
                check("R2", "read data while stray valid", 32'(rsp_rdata), 32'(exp_rd));
                break;
            end
            @(negedge clk);
        end
        check("R2", "done seen", 32'(seen), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R2", "no bus cycle from stray request", 32'(bus_cyc), 32'd0);
        run_txn("R2", 20'h00040, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_fill();
        t_aligned_word();
        t_byte_even();
        t_byte_odd();
        t_word_odd();
        t_wrap();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule